// File: doc/BRIEF.md
# Timer Output Pin Controller

This block drives a single timer output pin from the event pulses of two timer channels. One channel acts as the master and the other as the slave. Three static control inputs shape the behaviour. The mode input picks toggle or set/reset operation. The polarity input swaps the set and reset roles of the two events. The enable input chooses whether the timer or software owns the pin.

In toggle mode, each slave event inverts the output. In set/reset mode, one event drives the output high and the other drives it low. This gives PWM and one-shot waveforms. When both events arrive in the same cycle, the reset role wins, so a 0% duty cycle holds the pin low. While timer output is disabled, the events are blocked and a software write loads the pin level directly. This is how the starting level is set before the timer takes over. The held level can be read back at any time and always equals the pin.

Top module: `tmr_out_ctl`

## Requirements
- R1: A synchronous active-low reset clears the output level to 0 on the next rising clock edge.
- R2: With enable at 1 and mode at 0 (toggle), a slave event pulse inverts the output on the next rising edge.
- R3: With enable at 1 and mode at 0, a master event has no effect on the output, and neither does the polarity input.
- R4: With enable at 1, mode at 1 and polarity at 0, a master event drives the output to 1 and a slave event drives it to 0.
- R5: With enable at 1, mode at 1 and polarity at 1, a master event drives the output to 0 and a slave event drives it to 1.
- R6: With enable at 1 and mode at 1, master and slave events in the same cycle drive the output to 0 for either polarity.
- R7: With enable at 1, a software write leaves the output unchanged.
- R8: With enable at 0, events leave the output unchanged, and a software write loads the write data bit into the output on the next edge.
- R9: The readback output always equals the pin output. Changing the mode, polarity or enable inputs alone never changes the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| evt_master | input | 1 | Master channel event pulse |
| evt_slave | input | 1 | Slave channel event pulse |
| mode_combo | input | 1 | 0 selects toggle mode, 1 selects set/reset mode |
| pol_rev | input | 1 | 1 swaps the set and reset roles in set/reset mode |
| out_en | input | 1 | 1 gives the timer the pin, 0 gives software the pin |
| sw_wr | input | 1 | Software write strobe |
| sw_data | input | 1 | Level loaded by a software write |
| pin_out | output | 1 | Timer output pin |
| rd_level | output | 1 | Readback of the held output level |

## Verification
The block holds a single state bit, and that bit is the pin itself. Any wrong next-state choice, such as a lost toggle, a swapped role, the wrong winner when both events collide, or a write that should have been blocked, shows up at the pin one clock edge after the stimulus. The bench sets a known level through the software path before each scenario. It then checks the pin after every edge, so a fault appears within one cycle of its cause.

// File: rtl/tmr_out_ctl.sv
module tmr_out_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_master,
  input  logic evt_slave,
  input  logic mode_combo,
  input  logic pol_rev,
  input  logic out_en,
  input  logic sw_wr,
  input  logic sw_data,
  output logic pin_out,
  output logic rd_level
);

  logic lvl_q;
  logic set_ev;
  logic clr_ev;
  logic lvl_d;

  assign set_ev = pol_rev ? evt_slave  : evt_master;
  assign clr_ev = pol_rev ? evt_master : evt_slave;

  always_comb begin
    lvl_d = lvl_q;
    if (!out_en) begin
      if (sw_wr) lvl_d = sw_data;
    end else if (!mode_combo) begin
      if (evt_slave) lvl_d = ~lvl_q;
    end else if (clr_ev) begin
      lvl_d = 1'b0;
    end else if (set_ev) begin
      lvl_d = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl_d;
  end

  assign pin_out  = lvl_q;
  assign rd_level = lvl_q;

endmodule

// File: rtl/tmr_out_ctl_chk.sv
module tmr_out_ctl_chk (
  input logic clk,
  input logic rst_n,
  input logic evt_master,
  input logic evt_slave,
  input logic mode_combo,
  input logic pol_rev,
  input logic out_en,
  input logic sw_wr,
  input logic sw_data,
  input logic pin_out,
  input logic rd_level
);

  AST_RESET_LOW: assert property (@(posedge clk) !rst_n |=> !pin_out); // R1

  AST_TOGGLE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    out_en && !mode_combo && evt_slave |=> pin_out != $past(pin_out)); // R2

  AST_TOGGLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_en && !mode_combo && !evt_slave |=> $stable(pin_out)); // R3

  AST_FWD_SET: assert property (@(posedge clk) disable iff (!rst_n)
    out_en && mode_combo && !pol_rev && evt_master && !evt_slave |=> pin_out); // R4

  AST_FWD_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    out_en && mode_combo && !pol_rev && evt_slave |=> !pin_out); // R4

  AST_REV_SET: assert property (@(posedge clk) disable iff (!rst_n)
    out_en && mode_combo && pol_rev && evt_slave && !evt_master |=> pin_out); // R5

  AST_REV_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    out_en && mode_combo && pol_rev && evt_master |=> !pin_out); // R5

  AST_BOTH_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    out_en && mode_combo && evt_master && evt_slave |=> !pin_out); // R6

  AST_COMBO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_en && mode_combo && !evt_master && !evt_slave |=> $stable(pin_out)); // R7

  AST_SW_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en && sw_wr |=> pin_out == $past(sw_data)); // R8

  AST_SW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en && !sw_wr |=> $stable(pin_out)); // R8

  AST_READBACK: assert property (@(posedge clk) pin_out == rd_level); // R9

endmodule

bind tmr_out_ctl tmr_out_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .evt_master(evt_master), .evt_slave(evt_slave),
  .mode_combo(mode_combo), .pol_rev(pol_rev), .out_en(out_en),
  .sw_wr(sw_wr), .sw_data(sw_data), .pin_out(pin_out), .rd_level(rd_level)
);

// File: tb/test_tmr_out_ctl.sv
module test_tmr_out_ctl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic evt_master = 1'b0, evt_slave = 1'b0;
  logic mode_combo = 1'b0, pol_rev = 1'b0, out_en = 1'b0;
  logic sw_wr = 1'b0, sw_data = 1'b0;
  logic pin_out, rd_level;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  tmr_out_ctl i_tmr_out_ctl (
    .clk(clk), .rst_n(rst_n), .evt_master(evt_master), .evt_slave(evt_slave),
    .mode_combo(mode_combo), .pol_rev(pol_rev), .out_en(out_en),
    .sw_wr(sw_wr), .sw_data(sw_data), .pin_out(pin_out), .rd_level(rd_level)
  );

  task automatic check(input logic exp, input string tag);
    n_chk++;
    if (pin_out !== exp || rd_level !== exp) begin
      n_bad++;
      $display("FAIL %s: pin=%b rd=%b expected=%b", tag, pin_out, rd_level, exp);
    end
  endtask

  task automatic step(input logic m, input logic s, input logic w, input logic d);
    @(negedge clk);
    evt_master = m; evt_slave = s; sw_wr = w; sw_data = d;
    @(negedge clk);
    evt_master = 1'b0; evt_slave = 1'b0; sw_wr = 1'b0;
  endtask

  task automatic preset(input logic lvl);
    out_en = 1'b0;
    step(1'b0, 1'b0, 1'b1, lvl);
    check(lvl, "R8 preset");
  endtask

  task automatic t_reset;
    preset(1'b1);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    check(1'b0, "R1 reset");
  endtask

  task automatic t_toggle;
    preset(1'b0);
    out_en = 1'b1; mode_combo = 1'b0; pol_rev = 1'b0;
    step(1'b0, 1'b1, 1'b0, 1'b0); check(1'b1, "R2 toggle up");
    step(1'b0, 1'b1, 1'b0, 1'b0); check(1'b0, "R2 toggle down");
    step(1'b1, 1'b0, 1'b0, 1'b0); check(1'b0, "R3 master ignored");
    pol_rev = 1'b1;
    step(1'b1, 1'b0, 1'b0, 1'b0); check(1'b0, "R3 master ignored pol1");
    step(1'b0, 1'b1, 1'b0, 1'b0); check(1'b1, "R3 polarity ignored");
    step(1'b1, 1'b1, 1'b0, 1'b0); check(1'b0, "R3 both toggles once");
  endtask

  task automatic t_forward;
    preset(1'b0);
    out_en = 1'b1; mode_combo = 1'b1; pol_rev = 1'b0;
    step(1'b1, 1'b0, 1'b0, 1'b0); check(1'b1, "R4 master sets");
    step(1'b1, 1'b0, 1'b0, 1'b0); check(1'b1, "R4 set holds");
    step(1'b0, 1'b1, 1'b0, 1'b0); check(1'b0, "R4 slave clears");
    step(1'b0, 1'b1, 1'b0, 1'b0); check(1'b0, "R4 clear holds");
  endtask

  task automatic t_reverse;
    preset(1'b1);
    out_en = 1'b1; mode_combo = 1'b1; pol_rev = 1'b1;
    step(1'b1, 1'b0, 1'b0, 1'b0); check(1'b0, "R5 master clears");
    step(1'b0, 1'b1, 1'b0, 1'b0); check(1'b1, "R5 slave sets");
  endtask

  task automatic t_collide;
    preset(1'b1);
    out_en = 1'b1; mode_combo = 1'b1; pol_rev = 1'b0;
    step(1'b1, 1'b1, 1'b0, 1'b0); check(1'b0, "R6 both pol0");
    preset(1'b1);
    out_en = 1'b1; pol_rev = 1'b1;
    step(1'b1, 1'b1, 1'b0, 1'b0); check(1'b0, "R6 both pol1");
    preset(1'b0);
    out_en = 1'b1;
    step(1'b1, 1'b1, 1'b0, 1'b0); check(1'b0, "R6 both from low");
  endtask

  task automatic t_sw_gate;
    preset(1'b0);
    out_en = 1'b1; mode_combo = 1'b1; pol_rev = 1'b0;
    step(1'b0, 1'b0, 1'b1, 1'b1); check(1'b0, "R7 write blocked");
    step(1'b1, 1'b0, 1'b0, 1'b0); check(1'b1, "R7 event still works");
    step(1'b0, 1'b0, 1'b1, 1'b0); check(1'b1, "R7 write blocked high");
    out_en = 1'b0;
    step(1'b0, 1'b1, 1'b0, 1'b0); check(1'b1, "R8 slave blocked");
    mode_combo = 1'b0;
    step(1'b0, 1'b1, 1'b0, 1'b0); check(1'b1, "R8 toggle blocked");
    step(1'b0, 1'b0, 1'b1, 1'b0); check(1'b0, "R8 write low");
    mode_combo = 1'b1;
    step(1'b1, 1'b0, 1'b0, 1'b0); check(1'b0, "R8 master blocked");
    step(1'b0, 1'b0, 1'b1, 1'b1); check(1'b1, "R8 write high");
  endtask

  task automatic t_ctrl_only;
    preset(1'b1);
    @(negedge clk); out_en = 1'b1; mode_combo = 1'b1;
    @(negedge clk); check(1'b1, "R9 enable change");
    pol_rev = ~pol_rev;
    @(negedge clk); check(1'b1, "R9 polarity change");
    mode_combo = 1'b0;
    @(negedge clk); check(1'b1, "R9 mode change");
    out_en = 1'b0;
    @(negedge clk); check(1'b1, "R9 disable change");
  endtask

  initial begin
    fork
      begin
        repeat (2) @(negedge clk);
        check(1'b0, "R1 initial reset");
        rst_n = 1'b1;
        t_reset();
        t_toggle();
        t_forward();
        t_reverse();
        t_collide();
        t_sw_gate();
        t_ctrl_only();
      end
      begin
        repeat (5000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule